// File: doc/BRIEF.md
# Configurable UART character transmitter

This block turns one parallel byte into an asynchronous serial character whose shape comes from a small set of line-format inputs. A byte is offered with a valid/ready handshake. Once accepted, the transmitter drives a low start bit, then 5 to 8 data bits with the least significant bit first, then a high stop period. After that the line returns to its idle high level. All timing comes from a baud tick input that pulses at 16 times the bit rate, so one bit lasts 16 ticks.

The stop period depends on two format inputs together. With the two-stop select clear it lasts one bit. With the select set it lasts two bits, except with 5-bit characters, where it lasts one and a half bits (24 ticks). The format inputs are captured when a byte is accepted. Changes made while a character is being sent apply only to the next character. The same format settings are meant to be shared with a matching receiver.

Top module: `uart_fmt_tx`

## Requirements
- R1: While reset is applied and in the first cycle after it, tx_line is 1, tx_busy is 0 and in_ready is 1.
- R2: cfg_len codes 0, 1, 2 and 3 send 5, 6, 7 and 8 data bits, bit 0 of in_data first. Each data bit holds for 16 baud ticks.
- R3: In the cycle after a byte is accepted, tx_line is 0. It stays 0 for 16 baud ticks.
- R4: With cfg_two_stop = 0 the stop period is 16 ticks at level 1. Whenever tx_busy is 0, tx_line is 1.
- R5: With cfg_two_stop = 1 and cfg_len not 0, the stop period is 32 ticks.
- R6: With cfg_two_stop = 1 and cfg_len = 0, the stop period is 24 ticks.
- R7: A byte is accepted on a clock edge where in_valid and in_ready are both 1. From the next cycle until the stop period ends, tx_busy is 1 and in_ready is 0, and in_valid has no effect. In the cycle after the last stop tick, tx_busy is 0 and in_ready is 1.
- R8: cfg_len and cfg_two_stop are sampled only at acceptance. Changing them during a character does not alter that character.
- R9: Bits of in_data above the selected word length do not appear on tx_line.
- R10: tx_line changes only in the cycle after a baud tick, or in the cycle after an acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | Oversample tick, 16 per bit time |
| in_data | input | 8 | Character to send |
| in_valid | input | 1 | in_data is offered |
| in_ready | output | 1 | Transmitter can accept a character |
| cfg_len | input | 2 | Word length code (0..3 = 5..8 bits) |
| cfg_two_stop | input | 1 | Stop select: 0 one bit, 1 two bits (1.5 with 5-bit words) |
| tx_line | output | 1 | Serial output, idle high |
| tx_busy | output | 1 | A character is in progress |

## Verification
Every cycle, the assertions check the following. The line is low right after acceptance and high whenever the block is idle. The line moves only after a tick or an acceptance. The captured format stays fixed while busy. The data-bit index never goes past the selected length. The handshake closes after each acceptance. The exact number of ticks in each stop variant, the bit order, the masking of unused upper bits and the isolation from format changes mid-character can be seen only in the bench scenarios. There, a tick-counting model predicts the line level in every cycle under regular, continuous and irregular tick patterns.

// File: rtl/uart_fmt_tx_pkg.sv
package uart_fmt_tx_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_DATA  = 2'd2,
    PH_STOP  = 2'd3
  } phase_e;

  // number of data bits carried for a word length code
  function automatic int unsigned fmt_data_bits(input logic [1:0] len_code);
    return 32'(len_code) + 32'd5;
  endfunction

  // stop period in oversample ticks; the two-stop select with 5-bit words gives 1.5 bits
  function automatic int unsigned fmt_stop_ticks(input logic [1:0] len_code,
                                                 input logic two_stop,
                                                 input int unsigned osr);
    if (!two_stop)            return osr;
    else if (len_code == 2'd0) return osr + osr / 2;
    else                      return 2 * osr;
  endfunction

endpackage

// File: rtl/uart_fmt_tick_ctr.sv
module uart_fmt_tick_ctr #(
  parameter int TCW = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           tick,
  input  logic [TCW-1:0] limit,
  output logic           wrap
);
  logic [TCW-1:0] count_q;

  assign wrap = tick && (count_q == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clr)
      count_q <= '0;
    else if (tick)
      count_q <= wrap ? '0 : count_q + 1'b1;
  end
endmodule

// File: rtl/uart_fmt_shifter.sv
module uart_fmt_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              shift,
  output logic              serial_bit
);
  logic [DATA_W-1:0] shreg_q;

  assign serial_bit = shreg_q[0];

  always_ff @(posedge clk) begin
    if (rst)
      shreg_q <= '0;
    else if (load)
      shreg_q <= din;
    else if (shift)
      shreg_q <= {1'b0, shreg_q[DATA_W-1:1]};
  end
endmodule

// File: rtl/uart_fmt_cfg_latch.sv
module uart_fmt_cfg_latch (
  input  logic       clk,
  input  logic       rst,
  input  logic       capture,
  input  logic [1:0] len_in,
  input  logic       two_in,
  output logic [1:0] len_q,
  output logic       two_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= 2'd0;
      two_q <= 1'b0;
    end else if (capture) begin
      len_q <= len_in;
      two_q <= two_in;
    end
  end
endmodule

// File: rtl/uart_fmt_tx.sv
module uart_fmt_tx
  import uart_fmt_tx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_two_stop,
  output logic              tx_line,
  output logic              tx_busy
);
  localparam int TCW = $clog2(2 * OSR + 1);
  localparam int BIW = $clog2(DATA_W);

  phase_e          phase_q;
  logic [BIW-1:0]  bit_idx_q;
  logic [1:0]      len_q;
  logic            two_q;
  logic [TCW-1:0]  phase_limit;
  logic            phase_end;
  logic            serial_bit;

  // named events used by the checker
  logic accept_evt;
  logic bit_step_evt;
  logic last_bit;
  logic frame_end_evt;
  logic data_phase;

  assign in_ready      = (phase_q == PH_IDLE);
  assign tx_busy       = (phase_q != PH_IDLE);
  assign accept_evt    = in_valid && in_ready;
  assign data_phase    = (phase_q == PH_DATA);
  assign bit_step_evt  = data_phase && phase_end;
  assign last_bit      = (bit_idx_q == BIW'(fmt_data_bits(len_q) - 1));
  assign frame_end_evt = (phase_q == PH_STOP) && phase_end;

  always_comb begin
    if (phase_q == PH_STOP)
      phase_limit = TCW'(fmt_stop_ticks(len_q, two_q, OSR));
    else
      phase_limit = TCW'(OSR);
  end

  always_comb begin
    case (phase_q)
      PH_START: tx_line = 1'b0;
      PH_DATA:  tx_line = serial_bit;
      default:  tx_line = 1'b1;
    endcase
  end

  uart_fmt_tick_ctr #(.TCW(TCW)) u_ticks (
    .clk   (clk),
    .rst   (rst),
    .clr   (accept_evt || (phase_q == PH_IDLE)),
    .tick  (baud_tick),
    .limit (phase_limit),
    .wrap  (phase_end)
  );

  uart_fmt_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .load       (accept_evt),
    .din        (in_data),
    .shift      (bit_step_evt),
    .serial_bit (serial_bit)
  );

  uart_fmt_cfg_latch u_cfg (
    .clk     (clk),
    .rst     (rst),
    .capture (accept_evt),
    .len_in  (cfg_len),
    .two_in  (cfg_two_stop),
    .len_q   (len_q),
    .two_q   (two_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      bit_idx_q <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (accept_evt) phase_q <= PH_START;
        PH_START: if (phase_end) begin
          phase_q   <= PH_DATA;
          bit_idx_q <= '0;
        end
        PH_DATA: if (phase_end) begin
          if (last_bit) phase_q <= PH_STOP;
          else          bit_idx_q <= bit_idx_q + 1'b1;
        end
        PH_STOP: if (phase_end) phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_fmt_tx_chk.sv
module uart_fmt_tx_chk #(
  parameter int BIW = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           tick,
  input logic           accept_evt,
  input logic           data_phase,
  input logic [BIW-1:0] bit_idx,
  input logic [1:0]     len_q,
  input logic           two_q,
  input logic           tx_line,
  input logic           tx_busy,
  input logic           in_ready
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (tx_line && !tx_busy && in_ready));

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (rst)
    accept_evt |=> !tx_line);

  // R7
  handshake_close_chk: assert property (@(posedge clk) disable iff (rst)
    accept_evt |=> (tx_busy && !in_ready));

  // R4
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> tx_line);

  // R10
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(tick) && !$past(accept_evt)) |-> $stable(tx_line));

  // R8
  fmt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(tx_busy) && tx_busy) |-> ($stable(len_q) && $stable(two_q)));

  // R2
  bit_range_chk: assert property (@(posedge clk) disable iff (rst)
    data_phase |-> (int'(bit_idx) < int'(len_q) + 5));
endmodule

bind uart_fmt_tx uart_fmt_tx_chk #(.BIW(BIW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick       (baud_tick),
  .accept_evt (accept_evt),
  .data_phase (data_phase),
  .bit_idx    (bit_idx_q),
  .len_q      (len_q),
  .two_q      (two_q),
  .tx_line    (tx_line),
  .tx_busy    (tx_busy),
  .in_ready   (in_ready)
);

// File: tb/uart_fmt_tx_tb.sv
module uart_fmt_tx_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_two_stop = 1'b0;
  logic       tx_line;
  logic       tx_busy;

  int checks = 0;
  int errors = 0;
  int tick_mode = 0;
  string scen = "R1";

  always #10 clk = ~clk;

  uart_fmt_tx u_dut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .cfg_len(cfg_len), .cfg_two_stop(cfg_two_stop),
    .tx_line(tx_line), .tx_busy(tx_busy)
  );

  // behavioural model: counts ticks since acceptance
  bit     m_started = 0;
  bit     m_active  = 0;
  int     m_done    = 0;
  int     m_total   = 0;
  int     m_nb      = 8;
  int     m_stop    = 16;
  int     m_len     = 3;
  bit     m_two     = 0;
  bit [7:0] m_data  = '0;

  always @(posedge clk) begin
    m_started <= 1;
    if (rst) begin
      m_active = 0;
    end else if (m_active) begin
      if (baud_tick) begin
        m_done++;
        if (m_done == m_total) m_active = 0;
      end
    end else if (in_valid) begin
      m_data  = in_data;
      m_len   = int'(cfg_len);
      m_two   = cfg_two_stop;
      m_nb    = m_len + 5;
      m_stop  = !m_two ? 16 : (m_len == 0 ? 24 : 32);
      m_total = 16 + 16 * m_nb + m_stop;
      m_done  = 0;
      m_active = 1;
    end
  end

  function automatic bit exp_line();
    if (!m_active) return 1'b1;
    if (m_done < 16) return 1'b0;
    if (m_done < 16 + 16 * m_nb) return m_data[(m_done - 16) / 16];
    return 1'b1;
  endfunction

  function automatic string phase_tag();
    if (!m_active) return "R4";
    if (m_done < 16) return "R3";
    if (m_done < 16 + 16 * m_nb) return "R2";
    if (!m_two) return "R4";
    return (m_len == 0) ? "R6" : "R5";
  endfunction

  // compare on every falling edge
  always @(negedge clk) begin
    if (m_started) begin
      string tg;
      tg = rst ? "R1" : phase_tag();
      checks++;
      if (tx_line !== exp_line()) begin
        errors++;
        $display("FAIL %s (scenario %s) tx_line actual %b expected %b at %0t",
                 tg, scen, tx_line, exp_line(), $time);
      end
      checks++;
      if (tx_busy !== m_active || in_ready !== !m_active) begin
        errors++;
        $display("FAIL R7 (scenario %s) busy/ready actual %b/%b expected %b/%b at %0t",
                 scen, tx_busy, in_ready, m_active, !m_active, $time);
      end
    end
  end

  // tick generator: 0 every third cycle, 1 every cycle, 2 irregular
  initial begin
    logic [7:0] lfsr = 8'h5a;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (tick_mode)
        0: baud_tick = ($time / 20) % 3 == 0;
        1: baud_tick = 1'b1;
        default: baud_tick = lfsr[0] ^ lfsr[2];
      endcase
    end
  end

  task automatic send(input logic [7:0] d, input logic [1:0] len, input logic two);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_data = d; cfg_len = len; cfg_two_stop = two; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (tx_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin : main
    fork
      begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        // R2 each word length, one stop (R4)
        scen = "R2";
        for (int l = 0; l < 4; l++) begin
          send(8'hA5 ^ 8'(l * 37), 2'(l), 1'b0);
          wait_idle();
        end
        // R5 two stop bits with 6..8 bit words
        scen = "R5";
        for (int l = 1; l < 4; l++) begin
          send(8'h3C + 8'(l), 2'(l), 1'b1);
          wait_idle();
        end
        // R6 one and a half stop bits with 5-bit words
        scen = "R6";
        send(8'h15, 2'd0, 1'b1);
        wait_idle();
        // R9 upper bits set on short words
        scen = "R9";
        send(8'hE0 | 8'h0A, 2'd0, 1'b0);
        wait_idle();
        send(8'hC1, 2'd1, 1'b1);
        wait_idle();
        // R8 format changed mid-character
        scen = "R8";
        send(8'h6B, 2'd0, 1'b1);
        repeat (40) @(negedge clk);
        cfg_len = 2'd3; cfg_two_stop = 1'b0;
        wait_idle();
        send(8'h92, 2'd3, 1'b0);
        repeat (60) @(negedge clk);
        cfg_len = 2'd0; cfg_two_stop = 1'b1;
        wait_idle();
        // R7 valid held high across back-to-back frames, continuous ticks
        scen = "R7";
        tick_mode = 1;
        @(negedge clk);
        in_data = 8'h81; cfg_len = 2'd2; cfg_two_stop = 1'b1; in_valid = 1'b1;
        repeat (100) @(negedge clk);
        in_data = 8'h7E;
        repeat (300) @(negedge clk);
        in_valid = 1'b0;
        wait_idle();
        // R10 irregular tick pattern
        scen = "R10";
        tick_mode = 2;
        send(8'hD3, 2'd3, 1'b1);
        wait_idle();
        send(8'h2C, 2'd0, 1'b1);
        wait_idle();
        send(8'h55, 2'd1, 1'b0);
        wait_idle();
        // R1 reset in the middle of a frame
        scen = "R1";
        send(8'h00, 2'd3, 1'b1);
        repeat (30) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
      end
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog expired actual busy %b expected completion", tx_busy);
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule